// File: doc/BRIEF.md
# Prime-Modulus Bank Address Mapper

This block sits in front of a banked word memory. It turns a flat word address into a bank number and a word position inside that bank. The bank count is fixed at seven, which is prime. Strides that are powers of two therefore rotate through the banks and do not pile onto one of them. Each bank holds 2^OFS_W words. Because seven and 2^OFS_W have no common factor, every address below the total capacity of 7·2^OFS_W words lands on its own (bank, offset) pair.

The bank number is the address modulo seven. It is computed without a divider. The address is cut into 3-bit chunks and the chunks are summed, which works because 8 ≡ 1 (mod 7). That sum is folded again and a final step maps the value seven to zero. The offset is the low OFS_W bits of the address. An address at or above the capacity is flagged as out of range. Requests stream through a two-stage pipeline and one new address can be accepted every cycle.

Top module: `pbm_bank_map`

## Requirements
- R1: While reset is asserted, and after reset is released until the first request arrives, out_vld, out_bank, out_ofs and out_oor are all zero.
- R2: For an in-range request, out_bank equals in_addr modulo 7 and always lies in 0 to 6.
- R3: For an in-range request, out_ofs equals the low OFS_W bits of in_addr, i.e. in_addr modulo 2^OFS_W.
- R4: A request with in_addr ≥ 7·2^OFS_W drives out_oor high, and out_bank and out_ofs are both zero for that result. A request below that bound drives out_oor low.
- R5: out_vld is high in the cycle exactly two rising edges after in_vld was sampled high, and low when in_vld was sampled low. Back-to-back requests produce back-to-back results.
- R6: In any cycle where out_vld is low, out_bank, out_ofs and out_oor are all zero, whatever in_addr held.
- R7: Every address from 0 to 7·2^OFS_W−1 maps to a distinct (out_bank, out_ofs) pair.
- R8: Seven in-range addresses spaced 2^OFS_W words apart, starting at address 0, hit each of the seven banks exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Request valid |
| in_addr | input | ADDR_W | Flat word address |
| out_vld | output | 1 | Result valid, two cycles after the request |
| out_bank | output | 3 | Bank number, 0 to 6 |
| out_ofs | output | OFS_W | Word position inside the bank |
| out_oor | output | 1 | Address at or beyond the total capacity |

## Verification
All four results (valid, bank, offset and range flag) are due together, two rising edges after the request is sampled. The bench drives a new request at each falling edge and keeps a two-entry history of what it drove. At each falling edge it compares the outputs against the entry that is two edges old, so every check samples a settled output. The sweep covers every value of the 16-bit address space back to back. It then runs gapped and out-of-range patterns, where results must appear on exactly the delayed cycles and must read zero in the idle cycles in between.

// File: rtl/pbm_pkg.sv
package pbm_pkg;

  localparam int NBANK   = 7;
  localparam int BANK_W  = 3;
  localparam int CHUNK_W = 3;
  localparam int FOLD_W  = 8;

  // Reduce a value of at most 8 bits to its residue mod 7 by folding chunks.
  function automatic logic [BANK_W-1:0] mod7_narrow(input logic [FOLD_W-1:0] v);
    logic [4:0] s1;
    logic [3:0] s2;
    logic [2:0] s3;
    s1 = 5'(v[2:0]) + 5'(v[5:3]) + 5'(v[7:6]);
    s2 = 4'(s1[2:0]) + 4'(s1[4:3]);
    s3 = s2[2:0] + 3'(s2[3]);
    return (s3 == 3'd7) ? 3'd0 : s3;
  endfunction

  // Number of 3-bit chunks that cover an address width.
  function automatic int chunk_count(input int addr_w);
    return (addr_w + CHUNK_W - 1) / CHUNK_W;
  endfunction

endpackage

// File: rtl/pbm_fold.sv
module pbm_fold
  import pbm_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [FOLD_W-1:0] sum
);

  localparam int CHUNKS = chunk_count(ADDR_W);
  localparam int PAD_W  = CHUNKS * CHUNK_W;

  logic [PAD_W-1:0]   padded;
  logic [CHUNK_W-1:0] chunk [CHUNKS];

  assign padded = PAD_W'(addr);

  for (genvar g = 0; g < CHUNKS; g++) begin : g_chunk
    assign chunk[g] = padded[g*CHUNK_W +: CHUNK_W];
  end

  always_comb begin
    sum = '0;
    for (int i = 0; i < CHUNKS; i++) begin
      sum = sum + FOLD_W'(chunk[i]);
    end
  end

endmodule

// File: rtl/pbm_corr.sv
module pbm_corr
  import pbm_pkg::*;
(
  input  logic [FOLD_W-1:0] sum,
  output logic [BANK_W-1:0] bank
);

  assign bank = mod7_narrow(sum);

endmodule

// File: rtl/pbm_range.sv
module pbm_range #(
  parameter int ADDR_W = 16,
  parameter int OFS_W  = 9
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              oor
);

  localparam logic [ADDR_W:0] CAP = (ADDR_W+1)'(7) << OFS_W;

  assign oor = ({1'b0, addr} >= CAP);

endmodule

// File: rtl/pbm_bank_map.sv
module pbm_bank_map
  import pbm_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int OFS_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              out_vld,
  output logic [BANK_W-1:0] out_bank,
  output logic [OFS_W-1:0]  out_ofs,
  output logic              out_oor
);

  // Named internal events.
  logic [FOLD_W-1:0] fold_sum;
  logic              range_hit;
  logic              s1_take;
  logic [BANK_W-1:0] bank_calc;

  // Stage 1 state.
  logic              s1_vld;
  logic [FOLD_W-1:0] s1_sum;
  logic [OFS_W-1:0]  s1_ofs;
  logic              s1_oor;

  pbm_fold #(.ADDR_W(ADDR_W)) u_fold (
    .addr (in_addr),
    .sum  (fold_sum)
  );

  pbm_range #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_range (
    .addr (in_addr),
    .oor  (range_hit)
  );

  assign s1_take = in_vld && !range_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld <= 1'b0;
      s1_sum <= '0;
      s1_ofs <= '0;
      s1_oor <= 1'b0;
    end else begin
      s1_vld <= in_vld;
      s1_sum <= s1_take ? fold_sum : '0;
      s1_ofs <= s1_take ? in_addr[OFS_W-1:0] : '0;
      s1_oor <= in_vld && range_hit;
    end
  end

  pbm_corr u_corr (
    .sum  (s1_sum),
    .bank (bank_calc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld  <= 1'b0;
      out_bank <= '0;
      out_ofs  <= '0;
      out_oor  <= 1'b0;
    end else begin
      out_vld  <= s1_vld;
      out_bank <= (s1_vld && !s1_oor) ? bank_calc : '0;
      out_ofs  <= (s1_vld && !s1_oor) ? s1_ofs : '0;
      out_oor  <= s1_vld && s1_oor;
    end
  end

endmodule

// File: rtl/pbm_bank_map_chk.sv
module pbm_bank_map_chk
  import pbm_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int OFS_W  = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_vld,
  input logic [ADDR_W-1:0] in_addr,
  input logic              out_vld,
  input logic [BANK_W-1:0] out_bank,
  input logic [OFS_W-1:0]  out_ofs,
  input logic              out_oor
);

  localparam logic [ADDR_W:0] CAP = (ADDR_W+1)'(7) << OFS_W;

  // Cycles since reset, saturating, so $past never reaches into reset.
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  // R2: bank stays inside the prime range
  a_r2_bank_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> (out_bank < 3'(NBANK)));

  // R5: valid tracks request two edges later
  a_r5_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2) |-> (out_vld == $past(in_vld, 2)));

  // R3: offset is the low address bits of the request two edges back
  a_r3_offset_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && out_vld && !out_oor) |-> (out_ofs == $past(in_addr[OFS_W-1:0], 2)));

  // R4: range flag matches the capacity bound
  a_r4_oor_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && out_vld) |-> (out_oor == ({1'b0, $past(in_addr, 2)} >= CAP)));

  // R4: an out-of-range result carries zero bank and offset
  a_r4_oor_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && out_oor) |-> (out_bank == '0 && out_ofs == '0));

  // R6: idle cycles read as zero
  a_r6_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !out_vld |-> (out_bank == '0 && out_ofs == '0 && !out_oor));

endmodule

bind pbm_bank_map pbm_bank_map_chk #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_vld   (in_vld),
  .in_addr  (in_addr),
  .out_vld  (out_vld),
  .out_bank (out_bank),
  .out_ofs  (out_ofs),
  .out_oor  (out_oor)
);

// File: tb/pbm_bank_map_bench.sv
`timescale 1ns/1ps
module pbm_bank_map_bench;

  localparam int ADDR_W = 16;
  localparam int OFS_W  = 9;
  localparam int DEPTH  = 1 << OFS_W;
  localparam int CAP    = 7 * DEPTH;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_vld = 1'b0;
  logic [ADDR_W-1:0] in_addr = '0;
  logic              out_vld;
  logic [2:0]        out_bank;
  logic [OFS_W-1:0]  out_ofs;
  logic              out_oor;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  bit record_uniq = 0;
  bit record_hist = 0;
  bit seen [CAP];
  int seen_cnt = 0;
  int dup_cnt  = 0;
  int hits [7];

  logic       hv [2];
  logic [ADDR_W-1:0] ha [2];

  always #2.5 clk = ~clk;

  pbm_bank_map #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_pbm_bank_map (
    .clk (clk), .rst_n (rst_n), .in_vld (in_vld), .in_addr (in_addr),
    .out_vld (out_vld), .out_bank (out_bank), .out_ofs (out_ofs), .out_oor (out_oor)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic verify(input logic v, input logic [ADDR_W-1:0] a);
    int ai, eb, eo;
    bit eoor, ok;
    if (!v) begin
      // R5 and R6: idle result is all zero
      ok = !out_vld && out_bank == 0 && out_ofs == 0 && !out_oor;
      check(ok, "R5/R6 idle", {out_vld, out_oor, out_bank, out_ofs}, 0);
      return;
    end
    ai   = int'(a);
    eoor = ai >= CAP;
    eb   = eoor ? 0 : ai % 7;
    eo   = eoor ? 0 : ai % DEPTH;
    if (!out_vld) check(0, "R5 valid", 0, 1);
    else if (out_oor != eoor) check(0, "R4 range flag", int'(out_oor), int'(eoor));
    else if (int'(out_bank) != eb) check(0, "R2 bank", int'(out_bank), eb);
    else check(int'(out_ofs) == eo, "R3 offset", int'(out_ofs), eo);
    if (!eoor && record_uniq) begin
      if (seen[int'(out_bank) * DEPTH + int'(out_ofs)]) dup_cnt++;
      else begin
        seen[int'(out_bank) * DEPTH + int'(out_ofs)] = 1;
        seen_cnt++;
      end
    end
    if (!eoor && record_hist) hits[out_bank]++;
  endtask

  task automatic tick(input logic v, input logic [ADDR_W-1:0] a);
    @(negedge clk);
    verify(hv[1], ha[1]);
    hv[1] = hv[0]; ha[1] = ha[0];
    hv[0] = v;     ha[0] = a;
    in_vld  = v;
    in_addr = a;
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    hv[0] = 0; hv[1] = 0; ha[0] = '0; ha[1] = '0;
    for (int i = 0; i < 7; i++) hits[i] = 0;
    for (int i = 0; i < CAP; i++) seen[i] = 0;

    // R1: outputs zero during reset, even with a request present
    in_vld = 1'b1; in_addr = 16'd100;
    repeat (3) @(negedge clk);
    check(!out_vld && out_bank == 0 && out_ofs == 0 && !out_oor, "R1 in reset",
          {out_vld, out_oor, out_bank, out_ofs}, 0);
    in_vld = 1'b0; in_addr = '0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!out_vld && out_bank == 0 && out_ofs == 0 && !out_oor, "R1 after reset",
          {out_vld, out_oor, out_bank, out_ofs}, 0);

    // R2 R3 R4 R5 R7: exhaustive back-to-back sweep
    record_uniq = 1;
    for (int a = 0; a < (1 << ADDR_W); a++) tick(1'b1, ADDR_W'(a));
    tick(1'b0, '0);
    tick(1'b0, '0);
    record_uniq = 0;
    check(dup_cnt == 0, "R7 duplicate pairs", dup_cnt, 0);
    check(seen_cnt == CAP, "R7 distinct pairs", seen_cnt, CAP);

    // R8: stride of the bank depth spreads over all banks
    record_hist = 1;
    for (int k = 0; k < 7; k++) tick(1'b1, ADDR_W'(k * DEPTH));
    tick(1'b0, '0);
    tick(1'b0, '0);
    record_hist = 0;
    for (int b = 0; b < 7; b++) check(hits[b] == 1, "R8 stride bank hits", hits[b], 1);

    // R4 R5 R6: gapped pattern with boundary and out-of-range addresses
    tick(1'b1, ADDR_W'(CAP - 1));
    tick(1'b0, ADDR_W'(CAP - 1));
    tick(1'b1, ADDR_W'(CAP));
    tick(1'b0, 16'hFFFF);
    tick(1'b0, 16'h1234);
    tick(1'b1, 16'hFFFF);
    tick(1'b1, 16'd0);
    tick(1'b0, ADDR_W'(CAP));
    tick(1'b1, 16'd7);
    tick(1'b0, '0);
    tick(1'b0, '0);
    tick(1'b0, '0);

    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      finish_run();
    end
  end

endmodule